// File: doc/BRIEF.md
# Program/Erase Status Polling Generator

This block forms the byte returned on the data bus of a flash array controller while an embedded program or erase algorithm runs. When no algorithm is active, or when a read falls outside a suspended erase, it passes array data straight through. While an algorithm runs, it replaces the array data with a status byte. The status byte holds a polarity flag and two read-driven toggle flags. It also holds an error flag and an erase-window flag. The remaining bits are forced low.

The write sequencer pulses `op_start_i` once the last command write has been accepted (the fourth write for program, the sixth for erase). It pulses `done_i` when the algorithm completes. The bus interface pulses `rd_strobe_i` once per read access, meaning one pulse per output-enable edge, or per chip-enable edge while output enable is held low. If every block chosen for erase is protected, the block shows erase activity for a fixed cycle count `HOLD_CYC` and then returns to plain reads without waiting for `done_i`.

Status bit positions are fixed: bit 7 is the polarity flag, bit 6 the global toggle, bit 5 the error flag, bit 3 the erase-window flag, bit 2 the erase-block toggle, and bits 4, 1 and 0 are reserved.

Top module: `psp_status_gen`

## Requirements
- R1: With no algorithm active, and out of reset, `dq_o` equals `array_data_i` and `busy_o` is 0.
- R2: During a program, `dq_o[7]` is the inverse of the `prog_bit_i` value latched at `op_start_i`.
- R3: During an erase, including a protected-block erase, `dq_o[7]` is 0.
- R4: While `busy_o` is high, `dq_o[6]` inverts in the cycle after each `rd_strobe_i` pulse and holds otherwise. It starts at 0 for each new algorithm.
- R5: While `busy_o` is high, bits 4, 1 and 0 of `dq_o` are 0.
- R6: An erase started with `all_prot_i` high keeps `busy_o` high for exactly `HOLD_CYC` cycles and then returns to pass-through; `done_i` does not end it early.
- R7: While an erase is suspended (`suspend_i` high), `busy_o` is 0. A read with `rd_blk_i` equal to the erasing block returns 0x80 with the erase-block toggle in bit 2. Reads of other blocks return `array_data_i`. Dropping `suspend_i` resumes status reporting.
- R8: `dq_o[5]` becomes 1 in the cycle after `timeout_i` is seen during a running program or erase, and is cleared when the next algorithm starts.
- R9: During an erase, `dq_o[3]` is 0 for the first `ETIMER_CYC` cycles after the start edge and 1 from then on, with time spent suspended not counted. During a program, `dq_o[3]` is 0.
- R10: `dq_o[2]` inverts after a strobe only when `rd_blk_i` equals the erasing block, during erase or suspend. It is 0 during a program.
- R11: `op_start_i` is ignored while an algorithm is active or suspended, and `done_i` ends a program or a running erase in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_start_i | input | 1 | Algorithm start pulse |
| op_erase_i | input | 1 | 1 = erase, 0 = program, sampled with start |
| prog_bit_i | input | 1 | Bit 7 of the word being programmed |
| tgt_blk_i | input | BLK_W | Block targeted by the algorithm |
| all_prot_i | input | 1 | All blocks selected for erase are protected |
| rd_strobe_i | input | 1 | One pulse per read access |
| rd_blk_i | input | BLK_W | Block addressed by the current read |
| array_data_i | input | 8 | Array read data |
| suspend_i | input | 1 | Erase suspend request (level) |
| done_i | input | 1 | Algorithm completion pulse |
| timeout_i | input | 1 | Algorithm timeout error |
| dq_o | output | 8 | Read data or status byte |
| busy_o | output | 1 | Status byte is being driven |

## Verification
The assertions assume that `rd_strobe_i` is a single-cycle pulse per read access. They also assume that `done_i` and `timeout_i` arrive only while an algorithm could be running, and that `suspend_i` is raised only during an erase. The stimulus drives every pulse for exactly one cycle and applies suspend only inside an erase. It still issues stray `op_start_i` and `done_i` pulses at the moments where the requirements say they must be ignored.

// File: rtl/psp_pkg.sv
package psp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_SUSP  = 3'd4
  } psp_state_e;

  localparam int DQ_W      = 8;
  localparam int BIT_POLL  = 7;
  localparam int BIT_TOG   = 6;
  localparam int BIT_ERR   = 5;
  localparam int BIT_ETIM  = 3;
  localparam int BIT_BTOG  = 2;

  function automatic logic is_busy(psp_state_e s);
    return (s == ST_PROG) || (s == ST_ERASE) || (s == ST_HOLD);
  endfunction

  function automatic logic is_erasing(psp_state_e s);
    return (s == ST_ERASE) || (s == ST_HOLD) || (s == ST_SUSP);
  endfunction
endpackage

// File: rtl/psp_ctrl.sv
module psp_ctrl
  import psp_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int HOLD_CYC   = 12,
  parameter int ETIMER_CYC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_start_i,
  input  logic             op_erase_i,
  input  logic             prog_bit_i,
  input  logic [BLK_W-1:0] tgt_blk_i,
  input  logic             all_prot_i,
  input  logic             suspend_i,
  input  logic             done_i,
  input  logic             timeout_i,
  output psp_state_e       state_o,
  output logic             tgt_bit_o,
  output logic [BLK_W-1:0] tgt_blk_o,
  output logic             err_o,
  output logic             etim_done_o
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int ETIM_W = $clog2(ETIMER_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);
  localparam logic [ETIM_W-1:0] ETIM_MAX  = ETIM_W'(ETIMER_CYC);

  psp_state_e        state_q, state_d;
  logic [HOLD_W-1:0] hold_q;
  logic [ETIM_W-1:0] etim_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && op_start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (op_start_i) state_d = !op_erase_i ? ST_PROG :
                                          (all_prot_i ? ST_HOLD : ST_ERASE);
      ST_PROG:  if (done_i) state_d = ST_IDLE;
      ST_ERASE: if (done_i) state_d = ST_IDLE;
                else if (suspend_i) state_d = ST_SUSP;
      ST_HOLD:  if (hold_q == '0) state_d = ST_IDLE;
      ST_SUSP:  if (!suspend_i) state_d = ST_ERASE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      hold_q    <= '0;
      etim_q    <= '0;
      tgt_bit_o <= 1'b0;
      tgt_blk_o <= '0;
      err_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        tgt_bit_o <= prog_bit_i;
        tgt_blk_o <= tgt_blk_i;
        err_o     <= 1'b0;
        etim_q    <= '0;
        hold_q    <= HOLD_LAST;
      end else begin
        if ((state_q == ST_PROG || state_q == ST_ERASE) && timeout_i) err_o <= 1'b1;
        if ((state_q == ST_ERASE || state_q == ST_HOLD) && etim_q != ETIM_MAX)
          etim_q <= etim_q + 1'b1;
        if (state_q == ST_HOLD && hold_q != '0) hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign state_o     = state_q;
  assign etim_done_o = (etim_q == ETIM_MAX);
endmodule

// File: rtl/psp_toggle.sv
module psp_toggle
  import psp_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  psp_state_e       state_i,
  input  logic             rd_strobe_i,
  input  logic [BLK_W-1:0] rd_blk_i,
  input  logic [BLK_W-1:0] tgt_blk_i,
  output logic             tog_o,
  output logic             btog_o
);
  logic hit;
  assign hit = rd_strobe_i && (rd_blk_i == tgt_blk_i) && is_erasing(state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_o  <= 1'b0;
      btog_o <= 1'b0;
    end else if (state_i == ST_IDLE) begin
      tog_o  <= 1'b0;
      btog_o <= 1'b0;
    end else begin
      if (is_busy(state_i) && rd_strobe_i) tog_o <= ~tog_o;
      if (hit) btog_o <= ~btog_o;
    end
  end
endmodule

// File: rtl/psp_mux.sv
module psp_mux
  import psp_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  psp_state_e        state_i,
  input  logic              tgt_bit_i,
  input  logic [BLK_W-1:0]  tgt_blk_i,
  input  logic [BLK_W-1:0]  rd_blk_i,
  input  logic              err_i,
  input  logic              etim_done_i,
  input  logic              tog_i,
  input  logic              btog_i,
  input  logic [DQ_W-1:0]   array_data_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              busy_o
);
  logic [DQ_W-1:0] stat;
  logic            prog;

  assign prog = (state_i == ST_PROG);

  always_comb begin
    stat           = '0;
    stat[BIT_POLL] = prog ? ~tgt_bit_i : 1'b0;
    stat[BIT_TOG]  = tog_i;
    stat[BIT_ERR]  = err_i;
    stat[BIT_ETIM] = !prog && etim_done_i;
    stat[BIT_BTOG] = !prog && btog_i;
  end

  always_comb begin
    busy_o = is_busy(state_i);
    dq_o   = array_data_i;
    if (busy_o) begin
      dq_o = stat;
    end else if (state_i == ST_SUSP && rd_blk_i == tgt_blk_i) begin
      dq_o           = '0;
      dq_o[BIT_POLL] = 1'b1;
      dq_o[BIT_BTOG] = btog_i;
    end
  end
endmodule

// File: rtl/psp_status_gen.sv
module psp_status_gen
  import psp_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int HOLD_CYC   = 12,
  parameter int ETIMER_CYC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_start_i,
  input  logic             op_erase_i,
  input  logic             prog_bit_i,
  input  logic [BLK_W-1:0] tgt_blk_i,
  input  logic             all_prot_i,
  input  logic             rd_strobe_i,
  input  logic [BLK_W-1:0] rd_blk_i,
  input  logic [7:0]       array_data_i,
  input  logic             suspend_i,
  input  logic             done_i,
  input  logic             timeout_i,
  output logic [7:0]       dq_o,
  output logic             busy_o
);
  psp_state_e       state;
  logic             tgt_bit, err, etim_done, tog, btog;
  logic [BLK_W-1:0] tgt_blk;

  psp_ctrl #(.BLK_W(BLK_W), .HOLD_CYC(HOLD_CYC), .ETIMER_CYC(ETIMER_CYC)) u_ctrl (
    .clk_i, .rst_ni, .op_start_i, .op_erase_i, .prog_bit_i, .tgt_blk_i,
    .all_prot_i, .suspend_i, .done_i, .timeout_i,
    .state_o(state), .tgt_bit_o(tgt_bit), .tgt_blk_o(tgt_blk),
    .err_o(err), .etim_done_o(etim_done)
  );

  psp_toggle #(.BLK_W(BLK_W)) u_tog (
    .clk_i, .rst_ni, .state_i(state), .rd_strobe_i, .rd_blk_i,
    .tgt_blk_i(tgt_blk), .tog_o(tog), .btog_o(btog)
  );

  psp_mux #(.BLK_W(BLK_W)) u_mux (
    .state_i(state), .tgt_bit_i(tgt_bit), .tgt_blk_i(tgt_blk), .rd_blk_i,
    .err_i(err), .etim_done_i(etim_done), .tog_i(tog), .btog_i(btog),
    .array_data_i, .dq_o, .busy_o
  );
endmodule

// File: rtl/psp_status_chk.sv
module psp_status_chk
  import psp_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_strobe_i,
  input logic       done_i,
  input logic [7:0] array_data_i,
  input logic [7:0] dq_o,
  input logic       busy_o,
  input psp_state_e state
);
  assert_idle_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (dq_o == array_data_i && !busy_o));

  assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (dq_o[4] == 1'b0 && dq_o[1:0] == 2'b00));

  assert_toggle_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_strobe_i) |=> (!busy_o || dq_o[6] != $past(dq_o[6])));

  assert_toggle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rd_strobe_i) |=> (!busy_o || $stable(dq_o[6])));

  assert_etimer_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dq_o[3]) |=> (!busy_o || dq_o[3]));

  assert_prog_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PROG && !done_i) |=> (state == ST_PROG));

  assert_prog_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PROG && done_i) |=> (state == ST_IDLE));
endmodule

bind psp_status_gen psp_status_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_strobe_i(rd_strobe_i), .done_i(done_i),
  .array_data_i(array_data_i), .dq_o(dq_o), .busy_o(busy_o), .state(state)
);

// File: tb/psp_status_gen_tb.sv
module psp_status_gen_tb;
  localparam int BLK_W = 4;
  localparam int HC    = 12;
  localparam int ET    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_erase = 0, prog_bit = 0, all_prot = 0;
  logic rd_strobe = 0, suspend = 0, done = 0, timeout = 0;
  logic [BLK_W-1:0] tgt_blk = '0, rd_blk = '0;
  logic [7:0] arr = 8'h00;
  logic [7:0] dq;
  logic busy;

  int n_tests = 0, n_fail = 0;

  // reference model: 0 idle, 1 program, 2 erase, 3 protected hold, 4 suspended
  int m_st = 0, m_hold = 0, m_et = 0;
  bit m_bit = 0, m_t6 = 0, m_t2 = 0, m_err = 0;
  int m_blk = 0;

  always #10 clk = ~clk;

  psp_status_gen #(.BLK_W(BLK_W), .HOLD_CYC(HC), .ETIMER_CYC(ET)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_start_i(op_start), .op_erase_i(op_erase),
    .prog_bit_i(prog_bit), .tgt_blk_i(tgt_blk), .all_prot_i(all_prot),
    .rd_strobe_i(rd_strobe), .rd_blk_i(rd_blk), .array_data_i(arr),
    .suspend_i(suspend), .done_i(done), .timeout_i(timeout),
    .dq_o(dq), .busy_o(busy)
  );

  function automatic logic [8:0] expect_out();
    logic [7:0] e;
    bit b;
    b = (m_st >= 1 && m_st <= 3);
    e = arr;
    if (b) begin
      e = 8'h00;
      e[7] = (m_st == 1) ? ~m_bit : 1'b0;
      e[6] = m_t6;
      e[5] = m_err;
      e[3] = (m_st != 1) && (m_et >= ET);
      e[2] = (m_st != 1) && m_t2;
    end else if (m_st == 4 && int'(rd_blk) == m_blk) begin
      e = 8'h80;
      e[2] = m_t2;
    end
    return {b, e};
  endfunction

  task automatic model_step();
    int ns;
    ns = m_st;
    if (m_st == 0) begin
      if (op_start) begin
        ns = !op_erase ? 1 : (all_prot ? 3 : 2);
        m_bit = prog_bit; m_blk = int'(tgt_blk);
        m_err = 0; m_et = 0; m_hold = HC - 1;
      end
      m_t6 = 0; m_t2 = 0;
    end else begin
      if (m_st <= 3 && rd_strobe) m_t6 = ~m_t6;
      if (m_st >= 2 && rd_strobe && int'(rd_blk) == m_blk) m_t2 = ~m_t2;
      if ((m_st == 1 || m_st == 2) && timeout) m_err = 1;
      if ((m_st == 2 || m_st == 3) && m_et < ET) m_et++;
      case (m_st)
        1: if (done) ns = 0;
        2: if (done) ns = 0; else if (suspend) ns = 4;
        3: if (m_hold == 0) ns = 0; else m_hold--;
        4: if (!suspend) ns = 2;
        default: ;
      endcase
    end
    m_st = ns;
  endtask

  task automatic check(string req);
    logic [8:0] e;
    e = expect_out();
    n_tests++;
    if ({busy, dq} !== e) begin
      n_fail++;
      $display("FAIL %s: busy/dq got %b/%h expected %b/%h", req, busy, dq, e[8], e[7:0]);
    end
  endtask

  task automatic tick(string req);
    #8;
    check(req);
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
  endtask

  task automatic pulse_start(bit er, bit pb, int blk, bit prot, string req);
    op_start = 1; op_erase = er; prog_bit = pb; tgt_blk = BLK_W'(blk); all_prot = prot;
    tick(req);
    op_start = 0; all_prot = 0;
  endtask

  task automatic rd(int blk, logic [7:0] a, string req);
    rd_strobe = 1; rd_blk = BLK_W'(blk); arr = a;
    tick(req);
    rd_strobe = 0;
  endtask

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    arr = 8'h5A;
    #5;
    check("R1 reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    arr = 8'hC3; tick("R1");
    arr = 8'h3C; tick("R1");

    // program, data bit 1
    pulse_start(0, 1, 3, 0, "R1");
    for (int i = 0; i < 4; i++) rd(3, 8'hFF, "R2 R4 R5");
    tick("R4 hold");
    pulse_start(1, 0, 7, 0, "R11 start ignored");
    rd(9, 8'h11, "R10 prog dq2");
    timeout = 1; tick("R8"); timeout = 0;
    tick("R8 set");
    done = 1; tick("R11"); done = 0;
    arr = 8'hA5; tick("R1 after done");

    // program, data bit 0, error cleared by new start
    pulse_start(0, 0, 1, 0, "R1");
    rd(1, 8'h00, "R2 R8 cleared");
    rd(1, 8'h00, "R4");
    done = 1; tick("R11"); done = 0;

    // erase block 5
    pulse_start(1, 0, 5, 0, "R1");
    for (int i = 0; i < ET + 2; i++) begin
      if (i % 3 == 0) rd(5, 8'h77, "R3 R9 R10");
      else if (i % 3 == 1) rd(2, 8'h77, "R10 other block");
      else tick("R9");
    end
    suspend = 1; tick("R7 enter");
    rd(5, 8'h12, "R7 erasing block");
    rd(6, 8'h34, "R7 other block");
    op_start = 1; rd(5, 8'h56, "R11 start in suspend"); op_start = 0;
    done = 1; tick("R11 done in suspend"); done = 0;
    suspend = 0; tick("R7 resume");
    rd(5, 8'h00, "R4 R10");
    timeout = 1; tick("R8 erase"); timeout = 0;
    tick("R8");
    done = 1; tick("R11"); done = 0;
    tick("R1");

    // protected-block erase
    pulse_start(1, 1, 4, 1, "R1");
    for (int i = 0; i < HC + 3; i++) begin
      if (i == 2) begin done = 1; tick("R6 done ignored"); done = 0; end
      else if (i % 2 == 0) rd(4, 8'hE1, "R6 R3 R4");
      else tick("R6 R9");
    end
    arr = 8'h9F; tick("R6 back to reads");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule